// File: doc/BRIEF.md
# Buffered Reload PWM Timer

A 16-bit up-counter that produces a pulse-width-modulated waveform whose period and high time are set through two programmable values. Software writes these values into holding registers. The counter and the output logic never compare against the holding registers. They compare only against shadow copies, so a half-finished update cannot distort a cycle in progress.

When the timer is enabled, the shadow copies are filled and counting starts from zero. After that, new values pass into the shadows only at a period boundary, and only if the duty register was written since the last transfer. Writing the period by itself therefore arms nothing. To change only the period, software writes the period and then writes the unchanged duty value again. The counter advances on each cycle in which the tick input is high, so an external prescaler sets the counting rate.

The block has four outputs. The first is the PWM waveform. The second is a square wave that changes level at every period boundary. The last two are single-cycle event pulses, one for a period match and one for a duty match.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the timer is disabled and all four outputs are low.
- R2: A write with `wr_sel_i`=0 sets the enable bit from `wr_data_i[0]`. When that write changes the bit from 0 to 1, the current period and duty register values are copied into their shadows, and the counter starts from 0 on the next cycle.
- R3: While enabled, the counter advances by one on each cycle with `tick_i` high. It holds on cycles with `tick_i` low. On a tick with the count equal to the period shadow, it returns to 0, so one period is period+1 ticks long.
- R4: While enabled, `pwm_o` is high when the count is below the duty shadow. It goes low when the count reaches the duty shadow and goes high again when the counter wraps.
- R5: A duty shadow of 0 keeps `pwm_o` low for the whole period. A duty shadow greater than the period shadow keeps it high for the whole period.
- R6: `tgl_o` changes level one cycle after each tick on which the count equals the period shadow.
- R7: `irq_per_o` is high for exactly one cycle after a tick on which the count equals the period shadow. `irq_duty_o` is high for exactly one cycle after a tick on which the count equals the duty shadow.
- R8: A write with `wr_sel_i`=1 loads the period register only. If no duty write follows, later period matches leave both shadows unchanged.
- R9: A write with `wr_sel_i`=2 loads the duty register and arms a reload. At the next period match, both shadows take the current register values and the arm is cleared.
- R10: A duty write in the same cycle as a period match does not affect the transfer made at that match. It arms the transfer at the following match.
- R11: Writing 0 to the enable bit holds the counter at 0 and keeps all outputs low with no event pulses. Register writes while disabled do not arm a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 period, 2 duty |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM waveform |
| tgl_o | output | 1 | Square wave that changes level at each period match |
| irq_per_o | output | 1 | Period-match event pulse |
| irq_duty_o | output | 1 | Duty-match event pulse |

## Verification
The collision that matters is a duty write arriving in the same cycle as the period match that would otherwise perform a reload. The bench tracks the counter in its own model and holds off until the cycle in which the count equals the period shadow with a tick present. It then issues the duty write in exactly that cycle. The scoreboard checks that the first match after the write keeps the old period and duty, and that the match after that switches to the new values in both the waveform and the event pulses.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         per_hit_i,
  output logic         en_o,
  output logic         en_nxt_o,
  output logic [W-1:0] per_buf_o,
  output logic [W-1:0] duty_buf_o
);
  import pwm_pkg::*;

  logic         en_q, arm_q;
  logic [W-1:0] per_q, duty_q, per_buf_q, duty_buf_q;
  logic         wr_ctrl, wr_per, wr_duty, start;

  assign wr_ctrl  = wr_i && (wr_sel_i == SEL_CTRL);
  assign wr_per   = wr_i && (wr_sel_i == SEL_PER);
  assign wr_duty  = wr_i && (wr_sel_i == SEL_DUTY);
  assign en_nxt_o = wr_ctrl ? wr_data_i[0] : en_q;
  assign start    = wr_ctrl && wr_data_i[0] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      en_q <= en_nxt_o;
      if (wr_per)  per_q  <= wr_data_i;
      if (wr_duty) duty_q <= wr_data_i;
    end
  end

  // arm: set by duty write, consumed at period match; write wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b0;
    else if (!en_q)     arm_q <= 1'b0;
    else if (wr_duty)   arm_q <= 1'b1;
    else if (per_hit_i) arm_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf_q  <= '0;
      duty_buf_q <= '0;
    end else if (start || (per_hit_i && arm_q)) begin
      per_buf_q  <= per_q;
      duty_buf_q <= duty_q;
    end
  end

  assign en_o       = en_q;
  assign per_buf_o  = per_buf_q;
  assign duty_buf_o = duty_buf_q;

  AST_PER_ONLY_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_per && !arm_q) |=> !arm_q); // R8
  AST_NO_RELOAD_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && per_hit_i && !arm_q) |=> ($stable(per_buf_q) && $stable(duty_buf_q))); // R8
  AST_BUF_HOLD_MIDCYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !per_hit_i) |=> ($stable(per_buf_q) && $stable(duty_buf_q))); // R9
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         en_nxt_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_buf_i,
  input  logic [W-1:0] duty_buf_i,
  output logic [W-1:0] cnt_o,
  output logic         per_hit_o,
  output logic         duty_hit_o
);
  logic [W-1:0] cnt_q;

  assign per_hit_o  = en_i && tick_i && (cnt_q == per_buf_i);
  assign duty_hit_o = en_i && tick_i && (cnt_q == duty_buf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !en_nxt_i) cnt_q <= '0;
    else if (per_hit_o)          cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= per_buf_i)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (cnt_q == '0)); // R11
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         en_nxt_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] duty_buf_i,
  input  logic         per_hit_i,
  input  logic         duty_hit_i,
  output logic         pwm_o,
  output logic         tgl_o,
  output logic         irq_per_o,
  output logic         irq_duty_o
);
  logic tgl_q, irq_per_q, irq_duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q      <= 1'b0;
      irq_per_q  <= 1'b0;
      irq_duty_q <= 1'b0;
    end else begin
      irq_per_q  <= per_hit_i && en_nxt_i;
      irq_duty_q <= duty_hit_i && en_nxt_i;
      if (!en_nxt_i)      tgl_q <= 1'b0;
      else if (per_hit_i) tgl_q <= ~tgl_q;
    end
  end

  // duty 0 never high; duty above period never low
  assign pwm_o      = en_i && (cnt_i < duty_buf_i);
  assign tgl_o      = tgl_q;
  assign irq_per_o  = irq_per_q;
  assign irq_duty_o = irq_duty_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!pwm_o && !tgl_q && !irq_per_q && !irq_duty_q)); // R11
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic         pwm_o,
  output logic         tgl_o,
  output logic         irq_per_o,
  output logic         irq_duty_o
);
  logic         en, en_nxt, per_hit, duty_hit;
  logic [W-1:0] per_buf, duty_buf, cnt;

  pwm_shadow_regs #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .per_hit_i  (per_hit),
    .en_o       (en),
    .en_nxt_o   (en_nxt),
    .per_buf_o  (per_buf),
    .duty_buf_o (duty_buf)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .en_nxt_i   (en_nxt),
    .tick_i     (tick_i),
    .per_buf_i  (per_buf),
    .duty_buf_i (duty_buf),
    .cnt_o      (cnt),
    .per_hit_o  (per_hit),
    .duty_hit_o (duty_hit)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .en_nxt_i   (en_nxt),
    .cnt_i      (cnt),
    .duty_buf_i (duty_buf),
    .per_hit_i  (per_hit),
    .duty_hit_i (duty_hit),
    .pwm_o      (pwm_o),
    .tgl_o      (tgl_o),
    .irq_per_o  (irq_per_o),
    .irq_duty_o (irq_duty_o)
  );
endmodule

// File: tb/pwm_reload_timer_bench.sv
module pwm_reload_timer_bench;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         wr_i = 1'b0;
  logic [1:0]   wr_sel_i = 2'd0;
  logic [W-1:0] wr_data_i = '0;
  logic         pwm_o, tgl_o, irq_per_o, irq_duty_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] v;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // reference model state
  logic         m_en = 0, m_arm = 0, m_tgl = 0;
  logic [W-1:0] m_per = 0, m_duty = 0, m_pb = 0, m_db = 0, m_cnt = 0;

  always #5 clk_i = ~clk_i;

  pwm_reload_timer #(.W(W)) u_pwm_reload_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .wr_i       (wr_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .pwm_o      (pwm_o),
    .tgl_o      (tgl_o),
    .irq_per_o  (irq_per_o),
    .irq_duty_o (irq_duty_o)
  );

  // one clock of stimulus; pushes the outputs expected after the coming edge
  task automatic step(input bit wr, input logic [1:0] sel, input logic [W-1:0] d,
                      input bit tk, input string tag);
    logic en_n, start, pm, dm;
    logic [W-1:0] cnt_n;
    exp_t e;
    @(negedge clk_i);
    wr_i = wr; wr_sel_i = sel; wr_data_i = d; tick_i = tk;
    en_n  = (wr && sel == 2'd0) ? d[0] : m_en;
    start = wr && sel == 2'd0 && d[0] && !m_en;
    pm    = m_en && tk && (m_cnt == m_pb);
    dm    = m_en && tk && (m_cnt == m_db);
    if (!en_n || !m_en) cnt_n = '0;
    else if (pm)        cnt_n = '0;
    else if (tk)        cnt_n = m_cnt + 1'b1;
    else                cnt_n = m_cnt;
    if (start || (pm && m_arm)) begin m_pb = m_per; m_db = m_duty; end
    if (!m_en)                          m_arm = 1'b0;
    else if (wr && sel == 2'd2)         m_arm = 1'b1;
    else if (pm)                        m_arm = 1'b0;
    if (!en_n)   m_tgl = 1'b0;
    else if (pm) m_tgl = ~m_tgl;
    if (wr && sel == 2'd1) m_per = d;
    if (wr && sel == 2'd2) m_duty = d;
    m_en  = en_n;
    m_cnt = cnt_n;
    e.v   = {m_en && (m_cnt < m_db), m_tgl, pm && en_n, dm && en_n};
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run(input int n, input bit tk, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, tk, tag);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if ({pwm_o, tgl_o, irq_per_o, irq_duty_o} !== e.v) begin
          bad++;
          $display("FAIL %s pwm/tgl/iper/iduty act=%b exp=%b at %0t",
                   e.tag, {pwm_o, tgl_o, irq_per_o, irq_duty_o}, e.v, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(2, 1'b1, "R1");                         // reset state, disabled
    step(1, 2'd1, 16'd5, 1, "R2");              // period 5
    step(1, 2'd2, 16'd3, 1, "R11");             // duty write while disabled
    step(1, 2'd0, 16'd1, 1, "R2");              // enable: shadows loaded
    run(14, 1'b1, "R4");
    for (int i = 0; i < 8; i++) step(1'b0, 2'd0, '0, i[0], "R3");  // gapped ticks
    run(10, 1'b1, "R6");
    run(6, 1'b1, "R7");
    step(1, 2'd1, 16'd9, 1, "R8");              // period alone: no effect
    run(20, 1'b1, "R8");
    step(1, 2'd2, 16'd2, 1, "R9");              // arms reload of 9/2
    run(26, 1'b1, "R9");
    step(1, 2'd1, 16'd4, 1, "R10");             // new period, not armed
    while (!(m_en && m_cnt == m_pb)) step(1'b0, 2'd0, '0, 1'b1, "R10");
    step(1, 2'd2, 16'd1, 1, "R10");             // duty write on the match cycle
    run(22, 1'b1, "R10");
    step(1, 2'd2, 16'd0, 1, "R5");              // duty 0
    run(16, 1'b1, "R5");
    step(1, 2'd1, 16'd3, 1, "R5");
    step(1, 2'd2, 16'd7, 1, "R5");              // duty above period
    run(16, 1'b1, "R5");
    step(1, 2'd0, 16'd0, 1, "R11");             // disable
    run(5, 1'b1, "R11");
    step(1, 2'd2, 16'd2, 1, "R11");
    run(5, 1'b1, "R11");
    step(1, 2'd0, 16'd1, 1, "R2");              // restart from registers 3/2
    run(12, 1'b1, "R2");
    run(3, 1'b0, "R3");
    @(negedge clk_i);
    tick_i = 1'b0; wr_i = 1'b0;
    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule